// File: doc/BRIEF.md
# Virtual Page Hash Generator

This block takes an effective address, a segment identifier (VSID), a segment-size code, a page shift and a primary/secondary select. From these it forms the virtual page number (VPN) and the 39-bit page-table hash, then masks the hash down to a group index. The virtual page number is the full virtual address with its low 12 bits removed, kept to 64 bits. A page-table walker uses the group index to choose the entry group it searches. This block does not read or write the table memory.

The segment-size code decides two things: how many effective-address bits go into the VPN, and which hash formula applies. A write port loads the table-mask register. Each request is accepted on a single-cycle `in_valid`. One cycle later the result appears with an `out_valid` strobe. A request with an unsupported page shift is not executed; it produces a single-cycle error flag in its place.

Top module: `vpage_hash`

## Requirements
- R1: After reset, `out_valid` and `out_err` are 0, `out_vpn`, `out_hash` and `out_group` are 0, and the table mask is all ones (39 bits).
- R2: With `in_seg_1t`=0 (256 MB segment, segment shift 28), `out_vpn` = (`in_vsid` << 16) | `in_ea`[27:12].
- R3: With `in_seg_1t`=1 (1 TB segment, segment shift 40), `out_vpn` = ((`in_vsid` << 28) | `in_ea`[39:12]), keeping the low 64 bits.
- R4: For 256 MB segments, the primary hash is (VPN >> 16) XOR ((VPN & 0xFFFF) >> (page_shift − 12)).
- R5: For 1 TB segments, let s = VPN >> 28. The primary hash is s XOR (s << 25) XOR ((VPN & 0xFFFFFFF) >> (page_shift − 12)).
- R6: The hash keeps only its low 39 bits. Higher bits produced by the shifts are dropped.
- R7: When `in_secondary`=1, `out_hash` is the bitwise complement of the primary hash, within 39 bits.
- R8: `in_pshift` accepts only the values 12, 16 and 24. These shift the in-segment page bits right by 0, 4 and 12 places.
- R9: If a request carries any other `in_pshift` value, `out_err` is 1 for exactly the following cycle and `out_valid` stays 0. `out_vpn`, `out_hash` and `out_group` keep their previous values.
- R10: A legal request presented with `in_valid` produces `out_valid`=1 for exactly the following cycle. Back-to-back requests each produce their own result one cycle later.
- R11: `out_group` = `out_hash` AND the table mask. A mask write (`mask_we`) applies to requests presented in later cycles, not to a request presented in the same cycle.
- R12: When no request is accepted, `out_vpn`, `out_hash` and `out_group` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_ea | input | 64 | Effective address |
| in_vsid | input | 37 | Segment identifier |
| in_seg_1t | input | 1 | Segment size: 0 = 256 MB, 1 = 1 TB |
| in_pshift | input | 5 | Page shift (12, 16 or 24) |
| in_secondary | input | 1 | Select the secondary hash |
| mask_we | input | 1 | Table-mask write enable |
| mask_wdata | input | 39 | Table-mask write data |
| out_valid | output | 1 | Result strobe, one cycle after a legal request |
| out_err | output | 1 | Illegal page shift, one cycle after the request |
| out_vpn | output | 64 | Virtual page number |
| out_hash | output | 39 | Selected hash |
| out_group | output | 39 | Hash AND table mask |

## Verification
The bench checks both segment sizes at all three page shifts, with address bits set both inside and outside the segment field. A VPN built with the wrong segment shift would mix segment bits into the page bits, and a missing right shift would leave low page bits in the hash. A VSID with its top bits set exercises the 1 TB self-XOR with its 25-bit shift and the cut to 39 bits. Leaking bits above 39, or losing them, shows up directly in `out_hash`.

An illegal page shift (20) must raise the error flag and leave the previous outputs in place; a design that still latched the result would overwrite them. A mask write in the same cycle as a request must not affect that request's group, which catches a design that forwards the new mask early.

// File: rtl/vph_pkg.sv
package vph_pkg;
  parameter int EA_W      = 64;
  parameter int VSID_W    = 37;
  parameter int VPN_W     = 64;
  parameter int HASH_W    = 39;
  parameter int PS_W      = 5;
  parameter int PAGE_BASE = 12;
  parameter int SEG_S     = 28;
  parameter int SEG_L     = 40;
  parameter int XOR_SHL   = 25;

  localparam int LOW_S = SEG_S - PAGE_BASE;
  localparam int LOW_L = SEG_L - PAGE_BASE;

  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [HASH_W-1:0] hash_t;

  function automatic logic ps_legal(input logic [PS_W-1:0] ps);
    return (ps == PS_W'(12)) || (ps == PS_W'(16)) || (ps == PS_W'(24));
  endfunction

  function automatic vpn_t make_vpn(input logic [EA_W-1:0] ea,
                                    input logic [VSID_W-1:0] vsid,
                                    input logic seg_1t);
    int   lw;
    vpn_t pg;
    lw = seg_1t ? LOW_L : LOW_S;
    pg = VPN_W'(ea >> PAGE_BASE) & ((VPN_W'(1) << lw) - VPN_W'(1));
    return (VPN_W'(vsid) << lw) | pg;
  endfunction

  function automatic hash_t make_hash(input vpn_t vpn, input logic seg_1t,
                                      input logic [PS_W-1:0] ps);
    vpn_t lowpart, seg, h;
    logic [PS_W-1:0] sh;
    sh = ps - PS_W'(PAGE_BASE);
    if (!seg_1t) begin
      lowpart = vpn & ((VPN_W'(1) << LOW_S) - VPN_W'(1));
      h = (vpn >> LOW_S) ^ (lowpart >> sh);
    end else begin
      seg = vpn >> LOW_L;
      lowpart = vpn & ((VPN_W'(1) << LOW_L) - VPN_W'(1));
      h = seg ^ (seg << XOR_SHL) ^ (lowpart >> sh);
    end
    return h[HASH_W-1:0];
  endfunction
endpackage

// File: rtl/vph_vpn_unit.sv
module vph_vpn_unit import vph_pkg::*; (
  input  logic [EA_W-1:0]   ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg_1t,
  output vpn_t              vpn
);
  assign vpn = make_vpn(ea, vsid, seg_1t);
endmodule

// File: rtl/vph_hash_unit.sv
module vph_hash_unit import vph_pkg::*; (
  input  vpn_t            vpn,
  input  logic            seg_1t,
  input  logic [PS_W-1:0] pshift,
  input  logic            secondary,
  output logic            legal,
  output hash_t           hash
);
  hash_t primary;
  assign legal   = ps_legal(pshift);
  assign primary = make_hash(vpn, seg_1t, pshift);
  assign hash    = secondary ? ~primary : primary;
endmodule

// File: rtl/vph_mask_reg.sv
module vph_mask_reg import vph_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  hash_t wdata,
  output hash_t mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= wdata;
  end
endmodule

// File: rtl/vpage_hash.sv
module vpage_hash import vph_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EA_W-1:0]   in_ea,
  input  logic [VSID_W-1:0] in_vsid,
  input  logic              in_seg_1t,
  input  logic [PS_W-1:0]   in_pshift,
  input  logic              in_secondary,
  input  logic              mask_we,
  input  logic [HASH_W-1:0] mask_wdata,
  output logic              out_valid,
  output logic              out_err,
  output logic [VPN_W-1:0]  out_vpn,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_group
);
  vpn_t  vpn_c;
  hash_t hash_c;
  hash_t mask_q;
  logic  legal_c;
  logic  acc_ok;
  logic  acc_bad;

  vph_vpn_unit u_vpn (.ea(in_ea), .vsid(in_vsid), .seg_1t(in_seg_1t), .vpn(vpn_c));

  vph_hash_unit u_hash (.vpn(vpn_c), .seg_1t(in_seg_1t), .pshift(in_pshift),
                        .secondary(in_secondary), .legal(legal_c), .hash(hash_c));

  vph_mask_reg u_mask (.clk(clk), .rst_n(rst_n), .we(mask_we),
                       .wdata(mask_wdata), .mask_q(mask_q));

  assign acc_ok  = in_valid &  legal_c;
  assign acc_bad = in_valid & ~legal_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_vpn   <= '0;
      out_hash  <= '0;
      out_group <= '0;
    end else begin
      out_valid <= acc_ok;
      out_err   <= acc_bad;
      if (acc_ok) begin
        out_vpn   <= vpn_c;
        out_hash  <= hash_c;
        out_group <= hash_c & mask_q;
      end
    end
  end
endmodule

// File: rtl/vpage_hash_chk.sv
module vpage_hash_chk import vph_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PS_W-1:0]   in_pshift,
  input logic              acc_ok,
  input logic              acc_bad,
  input logic              out_valid,
  input logic              out_err,
  input logic [VPN_W-1:0]  out_vpn,
  input logic [HASH_W-1:0] out_hash,
  input logic [HASH_W-1:0] out_group
);
  logic ps_ok;
  assign ps_ok = (in_pshift == 5'd12) || (in_pshift == 5'd16) || (in_pshift == 5'd24);

  // R10
  legal_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ps_ok) |=> out_valid);
  // R10
  valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc_ok));
  // R9
  bad_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ps_ok) |=> (out_err && !out_valid));
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  // R8
  accept_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_ok, acc_bad}));
  // R11
  group_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_group & ~out_hash) == '0));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> ($stable(out_vpn) && $stable(out_hash) && $stable(out_group)));
endmodule

bind vpage_hash vpage_hash_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pshift(in_pshift),
  .acc_ok(acc_ok), .acc_bad(acc_bad), .out_valid(out_valid), .out_err(out_err),
  .out_vpn(out_vpn), .out_hash(out_hash), .out_group(out_group)
);

// File: tb/vpage_hash_tb.sv
module vpage_hash_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_ea = '0;
  logic [36:0] in_vsid = '0;
  logic        in_seg_1t = 1'b0;
  logic [4:0]  in_pshift = 5'd12;
  logic        in_secondary = 1'b0;
  logic        mask_we = 1'b0;
  logic [38:0] mask_wdata = '0;
  logic        out_valid, out_err;
  logic [63:0] out_vpn;
  logic [38:0] out_hash, out_group;

  int n_chk = 0;
  int n_bad = 0;
  logic [38:0] mask_model = '1;

  always #10 clk = ~clk;

  vpage_hash u_dut (.*);

  function automatic logic [63:0] ref_vpn(input logic [63:0] ea, input logic [36:0] v, input logic big);
    if (big) return {v[35:0], ea[39:12]};
    return {11'b0, v, ea[27:12]};
  endfunction

  function automatic logic [38:0] ref_hash(input logic [63:0] p, input logic big,
                                           input int ps, input logic sec);
    logic [63:0] t, h;
    int sh;
    sh = (ps == 24) ? 12 : (ps == 16) ? 4 : 0;
    if (!big) h = {16'b0, p[63:16]} ^ ({48'b0, p[15:0]} >> sh);
    else begin
      t = {28'b0, p[63:28]};
      h = t ^ (t << 25) ^ ({36'b0, p[27:0]} >> sh);
    end
    return sec ? ~h[38:0] : h[38:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] ea, input logic [36:0] v, input logic big,
                       input int ps, input logic sec);
    @(negedge clk);
    in_valid = 1'b1; in_ea = ea; in_vsid = v; in_seg_1t = big;
    in_pshift = 5'(ps); in_secondary = sec;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [63:0] ea, input logic [36:0] v,
                         input logic big, input int ps, input logic sec);
    logic [63:0] p;
    logic [38:0] h;
    p = ref_vpn(ea, v, big);
    h = ref_hash(p, big, ps, sec);
    drive(ea, v, big, ps, sec);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " vpn"}, out_vpn, p);
    chk({req, " hash"}, 64'(out_hash), 64'(h));
    chk({req, " group"}, 64'(out_group), 64'(h & mask_model));
    @(negedge clk);
    chk({req, " R10 strobe drops"}, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 err", 64'(out_err), 0);
    chk("R1 vpn", out_vpn, 0);
    chk("R1 hash", 64'(out_hash), 0);
    chk("R1 group", 64'(out_group), 0);
  endtask

  task automatic t_small_seg;
    run_one("R2 R4 ps12", 64'h0123_4567_89AB_CDEF, 37'h1_2345_6789, 1'b0, 12, 1'b0);
    run_one("R2 R4 R8 ps16", 64'hFFFF_FFFF_F00F_F000, 37'h0_0F0F_0F0F, 1'b0, 16, 1'b0);
    run_one("R2 R4 R8 ps24", 64'h0000_0000_0FFF_F000, 37'h1_FFFF_FFFF, 1'b0, 24, 1'b0);
  endtask

  task automatic t_large_seg;
    run_one("R3 R5 ps12", 64'hDEAD_BEEF_CAFE_1234, 37'h0_00AB_CDEF, 1'b1, 12, 1'b0);
    run_one("R3 R5 R8 ps16", 64'h0000_00FF_FFFF_F000, 37'h0_0123_4567, 1'b1, 16, 1'b0);
    run_one("R3 R5 R6 ps24", 64'h1234_0056_789A_B000, 37'h1_FFFF_FFFF, 1'b1, 24, 1'b0);
  endtask

  task automatic t_secondary;
    run_one("R7 small", 64'h0000_0000_1234_5000, 37'h0_0000_0042, 1'b0, 12, 1'b1);
    run_one("R7 large R6", 64'h0000_0055_AAAA_5000, 37'h1_8000_0001, 1'b1, 16, 1'b1);
  endtask

  task automatic t_illegal;
    logic [63:0] pv;
    logic [38:0] ph, pg;
    pv = out_vpn; ph = out_hash; pg = out_group;
    drive(64'hFFFF_FFFF_FFFF_FFFF, 37'h1_5555_5555, 1'b0, 20, 1'b0);
    chk("R9 err", 64'(out_err), 1);
    chk("R9 no valid", 64'(out_valid), 0);
    chk("R9 vpn held", out_vpn, pv);
    chk("R9 hash held", 64'(out_hash), 64'(ph));
    chk("R9 group held", 64'(out_group), 64'(pg));
    @(negedge clk);
    chk("R9 err one cycle", 64'(out_err), 0);
    chk("R12 hold idle", 64'(out_hash), 64'(ph));
  endtask

  task automatic t_back_to_back;
    logic [63:0] p1, p2;
    p1 = ref_vpn(64'h0000_0000_0ABC_D000, 37'h0_0000_1111, 1'b0);
    p2 = ref_vpn(64'h0000_0012_3456_7000, 37'h0_0000_2222, 1'b1);
    @(negedge clk);
    in_valid = 1; in_ea = 64'h0000_0000_0ABC_D000; in_vsid = 37'h0_0000_1111;
    in_seg_1t = 0; in_pshift = 5'd16; in_secondary = 0;
    @(negedge clk);
    chk("R10 first valid", 64'(out_valid), 1);
    chk("R10 first hash", 64'(out_hash), 64'(ref_hash(p1, 1'b0, 16, 1'b0)));
    in_ea = 64'h0000_0012_3456_7000; in_vsid = 37'h0_0000_2222; in_seg_1t = 1; in_pshift = 5'd12;
    @(negedge clk);
    in_valid = 0;
    chk("R10 second valid", 64'(out_valid), 1);
    chk("R10 second vpn", out_vpn, p2);
    chk("R10 second hash", 64'(out_hash), 64'(ref_hash(p2, 1'b1, 12, 1'b0)));
    @(negedge clk);
  endtask

  task automatic t_mask;
    logic [63:0] p;
    logic [38:0] h;
    p = ref_vpn(64'h0000_0000_0765_4000, 37'h0_1357_9BDF, 1'b0);
    h = ref_hash(p, 1'b0, 12, 1'b0);
    @(negedge clk);
    mask_we = 1; mask_wdata = 39'h00_0000_00FF;
    in_valid = 1; in_ea = 64'h0000_0000_0765_4000; in_vsid = 37'h0_1357_9BDF;
    in_seg_1t = 0; in_pshift = 5'd12; in_secondary = 0;
    @(negedge clk);
    mask_we = 0; in_valid = 0;
    chk("R11 same-cycle write unused", 64'(out_group), 64'(h & mask_model));
    mask_model = 39'h00_0000_00FF;
    run_one("R11 new mask", 64'h0000_0000_0765_4000, 37'h0_1357_9BDF, 1'b0, 12, 1'b0);
    @(negedge clk);
    mask_we = 1; mask_wdata = 39'h7F_F000_0F0F;
    @(negedge clk);
    mask_we = 0;
    chk("R12 mask write alone", 64'(out_valid), 0);
    mask_model = 39'h7F_F000_0F0F;
    run_one("R11 second mask", 64'h0000_00AB_CDEF_1000, 37'h0_0000_7777, 1'b1, 24, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_seg();
    t_large_seg();
    t_secondary();
    t_illegal();
    t_back_to_back();
    t_mask();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule